// File: doc/BRIEF.md
# Wiper Position Counter with Tap Decoder

This block keeps the volatile setting of a 64-tap digital potentiometer. It holds a 6-bit position and turns it into a one-hot vector that closes exactly one tap switch of the resistor string. Code 0 selects the tap at the low end and code 63 selects the tap at the high end.

The serial command decoder drives the position through several sources. A direct write carries a new value. A copy strobe loads one word, chosen by a select field, from the bank of saved settings. A step strobe, accepted only while an increment/decrement session is open, moves the position one tap up or down. A recall strobe loads saved word zero. The same recall happens by itself on the first clock edge after reset is released. The decoder produces one step strobe for each qualified serial-clock high pulse and holds the session open until chip select rises. The resistor string and its analog settling lie outside this block.

Top module: `wiper_counter`

## Requirements
- R1: While rstN is low, position reads 0 and taps reads 64'h1. On the first rising clock edge with rstN high, position loads saved word zero (bankData[5:0]) without any strobe.
- R2: taps is registered and one-hot at all times. Bit i is set exactly when position equals i, so code 0x00 selects bit 0 (low end) and code 0x3F selects bit 63 (high end). taps and position change on the same clock edge.
- R3: When directReq is high at a clock edge, position takes directData at that edge.
- R4: When copyReq is high at a clock edge, position takes saved word copySel, which is bankData[6*copySel+5 : 6*copySel], for any copySel from 0 to 3.
- R5: When stepPulse is high at a clock edge while stepOpen is high, position rises by one if stepUp is 1 and falls by one if stepUp is 0.
- R6: A stepPulse while stepOpen is low leaves position and taps unchanged.
- R7: Stepping saturates. A step up at 0x3F and a step down at 0x00 leave position unchanged.
- R8: When sources fire in the same cycle, the priority is recall (recallReq or the post-reset load), then copyReq, then directReq, then the step.
- R9: When recallReq is high at a clock edge, position loads saved word zero at any time after reset.
- R10: With no strobe active, position and taps hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| recallReq | input | 1 | Load saved word zero |
| copyReq | input | 1 | Load the saved word chosen by copySel |
| copySel | input | 2 | Index of the saved word for a copy |
| directReq | input | 1 | Load directData |
| directData | input | 6 | Value for a direct write |
| stepOpen | input | 1 | Increment/decrement session is open |
| stepPulse | input | 1 | One step strobe per qualified serial-clock pulse |
| stepUp | input | 1 | Step direction: 1 moves toward the high end, 0 toward the low end |
| bankData | input | 24 | Four saved 6-bit words; word k sits at bits 6k+5:6k |
| position | output | 6 | Current wiper position |
| taps | output | 64 | One-hot tap select |

## Verification
The assertions check the following on every cycle:
- taps matches the one-hot decode of position.
- The control never issues more than one action.
- A closed session never produces a step.
- Steps move by exactly one tap, or hold at the two ends.
- An idle cycle holds the position.
- Recall and copy win arbitration as ranked.

Only the bench's scenarios can show the following:
- The automatic load of word zero after reset.
- That each copy select fetches the right slice of the bank bus.
- That a direct write carries its data unchanged.
- That the full ranking resolves a cycle in which every source fires at once.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // One action per cycle, chosen by the control block
  typedef struct packed {
    logic loadBank;
    logic loadDirect;
    logic stepInc;
    logic stepDec;
  } wiperAct_t;

endpackage

// File: rtl/wiper_ctl.sv
module wiper_ctl
  import wiper_pkg::*;
#(
  parameter int BANK_N = 4,
  localparam int SEL_W = (BANK_N > 1) ? $clog2(BANK_N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             recallReq,
  input  logic             copyReq,
  input  logic [SEL_W-1:0] copySel,
  input  logic             directReq,
  input  logic             stepOpen,
  input  logic             stepPulse,
  input  logic             stepUp,
  output wiperAct_t        act,
  output logic [SEL_W-1:0] bankSel
);

  logic bootPending;
  logic recallEff;

  // Power-up recall pending until the first edge out of reset
  always_ff @(posedge clk) begin
    if (!rstN) bootPending <= 1'b1;
    else       bootPending <= 1'b0;
  end

  assign recallEff = bootPending | recallReq;

  // Fixed priority: recall, copy, direct write, step
  always_comb begin
    act     = '0;
    bankSel = '0;
    if (recallEff) begin
      act.loadBank = 1'b1;
    end else if (copyReq) begin
      act.loadBank = 1'b1;
      bankSel      = copySel;
    end else if (directReq) begin
      act.loadDirect = 1'b1;
    end else if (stepOpen && stepPulse) begin
      act.stepInc = stepUp;
      act.stepDec = !stepUp;
    end
  end

  // R8
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({act.loadBank, act.loadDirect, act.stepInc, act.stepDec}));

  // R8
  recall_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> (act.loadBank && bankSel == '0));

  // R8
  copy_over_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (copyReq && !recallReq && !bootPending) |-> (act.loadBank && bankSel == copySel));

  // R6
  closed_session_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepOpen |-> !(act.stepInc || act.stepDec));

endmodule

// File: rtl/wiper_path.sv
module wiper_path
  import wiper_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int BANK_N = 4,
  localparam int SEL_W = (BANK_N > 1) ? $clog2(BANK_N) : 1,
  localparam int TAP_N = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wiperAct_t               act,
  input  logic [SEL_W-1:0]        bankSel,
  input  logic [POS_W-1:0]        directData,
  input  logic [BANK_N*POS_W-1:0] bankData,
  output logic [POS_W-1:0]        position,
  output logic [TAP_N-1:0]        taps
);

  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] nextPos;
  logic [POS_W-1:0] bankWord;
  logic [TAP_N-1:0] tapsQ;
  logic [TAP_N-1:0] tapsNext;

  assign bankWord = bankData[bankSel*POS_W +: POS_W];

  // Next position, with saturating steps at both ends
  always_comb begin
    nextPos = posQ;
    if (act.loadBank)                          nextPos = bankWord;
    else if (act.loadDirect)                   nextPos = directData;
    else if (act.stepInc && posQ != POS_MAX)   nextPos = posQ + 1'b1;
    else if (act.stepDec && posQ != POS_MIN)   nextPos = posQ - 1'b1;
  end

  // Decode the next position so taps update on the same edge as posQ
  for (genvar i = 0; i < TAP_N; i++) begin : g_tap
    assign tapsNext[i] = (nextPos == POS_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ  <= '0;
      tapsQ <= {{(TAP_N-1){1'b0}}, 1'b1};
    end else begin
      posQ  <= nextPos;
      tapsQ <= tapsNext;
    end
  end

  assign position = posQ;
  assign taps     = tapsQ;

  // R2
  tap_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    tapsQ == ({{(TAP_N-1){1'b0}}, 1'b1} << posQ));

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act.stepInc && posQ != POS_MAX) |=> (posQ == $past(posQ) + 1'b1));

  // R5
  step_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act.stepDec && posQ != POS_MIN) |=> (posQ == $past(posQ) - 1'b1));

  // R7
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act.stepInc && posQ == POS_MAX) |=> (posQ == POS_MAX));

  // R7
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act.stepDec && posQ == POS_MIN) |=> (posQ == POS_MIN));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act == '0) |=> $stable(posQ));

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int BANK_N = 4,
  localparam int SEL_W = (BANK_N > 1) ? $clog2(BANK_N) : 1,
  localparam int TAP_N = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    recallReq,
  input  logic                    copyReq,
  input  logic [SEL_W-1:0]        copySel,
  input  logic                    directReq,
  input  logic [POS_W-1:0]        directData,
  input  logic                    stepOpen,
  input  logic                    stepPulse,
  input  logic                    stepUp,
  input  logic [BANK_N*POS_W-1:0] bankData,
  output logic [POS_W-1:0]        position,
  output logic [TAP_N-1:0]        taps
);

  wiperAct_t        act;
  logic [SEL_W-1:0] bankSel;

  wiper_ctl #(.BANK_N(BANK_N)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .recallReq (recallReq),
    .copyReq   (copyReq),
    .copySel   (copySel),
    .directReq (directReq),
    .stepOpen  (stepOpen),
    .stepPulse (stepPulse),
    .stepUp    (stepUp),
    .act       (act),
    .bankSel   (bankSel)
  );

  wiper_path #(.POS_W(POS_W), .BANK_N(BANK_N)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .act        (act),
    .bankSel    (bankSel),
    .directData (directData),
    .bankData   (bankData),
    .position   (position),
    .taps       (taps)
  );

endmodule

// File: tb/wiper_counter_bench.sv
module wiper_counter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        recallReq = 1'b0;
  logic        copyReq = 1'b0;
  logic [1:0]  copySel = 2'd0;
  logic        directReq = 1'b0;
  logic [5:0]  directData = 6'd0;
  logic        stepOpen = 1'b0;
  logic        stepPulse = 1'b0;
  logic        stepUp = 1'b0;
  logic [23:0] bankData = {6'h33, 6'h2C, 6'h15, 6'h2A};
  logic [5:0]  position;
  logic [63:0] taps;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wiper_counter u_wiper_counter (
    .clk(clk), .rstN(rstN), .recallReq(recallReq), .copyReq(copyReq),
    .copySel(copySel), .directReq(directReq), .directData(directData),
    .stepOpen(stepOpen), .stepPulse(stepPulse), .stepUp(stepUp),
    .bankData(bankData), .position(position), .taps(taps)
  );

  function automatic logic [5:0] word(input int k);
    return bankData[k*6 +: 6];
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chkPos(input string req, input logic [5:0] exp);
    chk(req, {58'd0, position}, {58'd0, exp});
    chk({req, " taps"}, taps, 64'd1 << exp);
  endtask

  task automatic directWrite(input logic [5:0] v);
    @(negedge clk); directReq = 1'b1; directData = v;
    @(negedge clk); directReq = 1'b0;
  endtask

  task automatic stepOnce(input logic up);
    @(negedge clk); stepPulse = 1'b1; stepUp = up;
    @(negedge clk); stepPulse = 1'b0;
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    chk("R1 reset pos", {58'd0, position}, 64'd0);
    chk("R1 reset taps", taps, 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chkPos("R1 boot load", word(0));
    repeat (3) @(negedge clk);
    chkPos("R10 idle hold", word(0));
  endtask

  task automatic tDirect;
    directWrite(6'h15); chkPos("R3 direct 15", 6'h15);
    directWrite(6'h3F); chkPos("R2 high end tap", 6'h3F);
    chk("R2 bit63", {63'd0, taps[63]}, 64'd1);
    directWrite(6'h00); chkPos("R2 low end tap", 6'h00);
    chk("R2 bit0", {63'd0, taps[0]}, 64'd1);
  endtask

  task automatic tCopy;
    for (int k = 3; k >= 0; k--) begin
      @(negedge clk); copyReq = 1'b1; copySel = 2'(k);
      @(negedge clk); copyReq = 1'b0;
      chkPos($sformatf("R4 copy word %0d", k), word(k));
    end
  endtask

  task automatic tStep;
    directWrite(6'h10);
    stepOpen = 1'b1;
    for (int i = 0; i < 3; i++) stepOnce(1'b1);
    chkPos("R5 step up x3", 6'h13);
    for (int i = 0; i < 5; i++) stepOnce(1'b0);
    chkPos("R5 step down x5", 6'h0E);
    stepOpen = 1'b0;
  endtask

  task automatic tClosed;
    directWrite(6'h20);
    stepOnce(1'b1); chkPos("R6 closed up ignored", 6'h20);
    stepOnce(1'b0); chkPos("R6 closed down ignored", 6'h20);
  endtask

  task automatic tSat;
    stepOpen = 1'b1;
    directWrite(6'h3F);
    stepOnce(1'b1); chkPos("R7 sat high", 6'h3F);
    stepOnce(1'b0); chkPos("R7 leave high", 6'h3E);
    directWrite(6'h00);
    stepOnce(1'b0); chkPos("R7 sat low", 6'h00);
    stepOpen = 1'b0;
  endtask

  task automatic tPriority;
    directWrite(6'h01);
    stepOpen = 1'b1;
    @(negedge clk);
    recallReq = 1'b1; copyReq = 1'b1; copySel = 2'd3;
    directReq = 1'b1; directData = 6'h05; stepPulse = 1'b1; stepUp = 1'b1;
    @(negedge clk); recallReq = 1'b0;
    chkPos("R8 recall first", word(0));
    @(negedge clk); copyReq = 1'b0;
    chkPos("R8 copy over direct", word(3));
    @(negedge clk); directReq = 1'b0;
    chkPos("R8 direct over step", 6'h05);
    @(negedge clk); stepPulse = 1'b0; stepOpen = 1'b0;
    chkPos("R8 step alone", 6'h06);
  endtask

  task automatic tRecall;
    directWrite(6'h07);
    @(negedge clk); recallReq = 1'b1;
    @(negedge clk); recallReq = 1'b0;
    chkPos("R9 recall word 0", word(0));
    repeat (4) @(negedge clk);
    chkPos("R10 hold after recall", word(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tReset;
    tDirect;
    tCopy;
    tStep;
    tClosed;
    tSat;
    tPriority;
    tRecall;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule